// File: doc/BRIEF.md
# Offset-Frequency Sampling Pulse Generator

This block times the narrow gate pulses that close a secondary-side sampling switch in a resonant ring-voltage converter. In ring operation the pulses come slightly slower than the primary switching rate, so the sampled secondary waveform aliases to a low-frequency sine of 20, 25 or 50 Hz. The nominal sample period is a fixed count of clock cycles. A second, long counter stretches one sample period by one clock each time it wraps, and the selected long modulus sets the alias frequency.

In DC operation (handset off hook, or ringing not requested) the pulses lock to the primary drive. Each pulse follows the phase-two rising-edge strobe from the primary driver by a programmed number of clocks, which sets the DC level left at the output. A drive enable and an over-current flag gate the output pulse. A one-clock pulse is the only output.

The control is a three-state machine. `ST_RING` emits a pulse on every wrap of the sample counter. `ST_LOCK_WAIT` waits for a primary strobe. `ST_LOCK_DELAY` counts down the programmed delay. Every state goes to `ST_LOCK_WAIT` when ring selection drops. From `ST_LOCK_WAIT`, a strobe with a non-zero delay leads to `ST_LOCK_DELAY`, and a zero delay fires at once and stays in the state. `ST_LOCK_DELAY` fires and returns to `ST_LOCK_WAIT` when its count reaches zero. Both lock states go back to `ST_RING` as soon as ring selection returns.

Top module: `spg_samp_gen`

## Requirements
- R1: After reset the pulse output is low, the state is `ST_RING` and both counters are at zero.
- R2: In ring operation, pulses are one clock wide and consecutive pulses are SAMP_MOD or SAMP_MOD+1 clocks apart.
- R3: `fsel` selects the long modulus. 2'b00 selects LONG_20HZ (default 4480), 2'b01 selects LONG_25HZ (3560) and 2'b10 selects LONG_50HZ (1800). Each wrap of the long counter lengthens exactly one sample interval by one clock, so about one interval per long period is SAMP_MOD+1.
- R4: Ring operation is selected only when `ring_en`=1, `off_hook`=0 and `fsel`≠2'b11. When that condition holds at a clock edge, the state is `ST_RING` after it. Otherwise the state is a lock state after it.
- R5: In lock operation, if `ph2_rise` is high at edge E, the pulse goes high for one clock after edge E+d. The delay d is the value of `dly_code`.
- R6: In lock operation, no pulse appears unless a strobe occurred within the preceding MAX_DLY clocks.
- R7: A `dly_code` above MAX_DLY (4) is treated as MAX_DLY.
- R8: A pulse is suppressed when `drv_en`=0 or `oc_trip`=1 at the clock edge on which it would be issued.
- R9: `fsel`=2'b11 with ringing requested and on hook gives lock operation.
- R10: The sample counter keeps running through lock operation. On return to ring operation, the pulse train resumes in its earlier phase, shifted only by long-counter slips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_en | input | 1 | Ringing requested |
| off_hook | input | 1 | Off-hook current flag |
| fsel | input | 2 | Ring frequency select |
| dly_code | input | DLY_W | Lock-mode delay in clocks |
| drv_en | input | 1 | Output enable, active high |
| oc_trip | input | 1 | Primary over-current flag, suppresses output |
| ph2_rise | input | 1 | One-clock strobe at the phase-two drive rising edge |
| samp_pulse | output | 1 | One-clock sampling pulse |

## Verification
The checker assumes two things about the primary driver's strobe. It is a single-clock pulse, and successive strobes are spaced by more than MAX_DLY+1 clocks, as a driver running at the sample period guarantees. Under those two conditions the one-clock-width and strobe-proximity properties hold. The bench sends each strobe only after the previous delay has expired, with long gaps between strobes. After every change of mode it waits for the state machine to settle before sending a strobe. It changes `fsel` only with a settle time before any measurement window.

// File: rtl/spg_pkg.sv
package spg_pkg;
    typedef enum logic [1:0] {
        ST_RING       = 2'd0,
        ST_LOCK_WAIT  = 2'd1,
        ST_LOCK_DELAY = 2'd2
    } spg_state_e;
endpackage

// File: rtl/spg_long_div.sv
module spg_long_div #(
    parameter int LONG_20HZ = 4480,
    parameter int LONG_25HZ = 3560,
    parameter int LONG_50HZ = 1800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] fsel,
    output logic       wrap
);
    localparam int MAX_A = (LONG_20HZ > LONG_25HZ) ? LONG_20HZ : LONG_25HZ;
    localparam int MAX_L = (MAX_A > LONG_50HZ) ? MAX_A : LONG_50HZ;
    localparam int LW    = $clog2(MAX_L + 1);

    logic [LW-1:0] cnt;
    logic [LW-1:0] last;

    always_comb begin
        unique case (fsel)
            2'b01:   last = LW'(LONG_25HZ - 1);
            2'b10:   last = LW'(LONG_50HZ - 1);
            default: last = LW'(LONG_20HZ - 1);
        endcase
    end

    // A shrink of the modulus while cnt sits above it wraps on the next edge.
    assign wrap = (cnt >= last);

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spg_phase_ctr.sv
module spg_phase_ctr #(
    parameter int SAMP_MOD = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic wrap_evt
);
    localparam int PW = $clog2(SAMP_MOD);
    localparam logic [PW-1:0] LAST = PW'(SAMP_MOD - 1);

    logic [PW-1:0] phase;

    assign wrap_evt = (phase == LAST) && !hold;

    always_ff @(posedge clk) begin
        if (!rst_n)         phase <= '0;
        else if (!hold) begin
            if (phase == LAST) phase <= '0;
            else               phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/spg_lock_fsm.sv
module spg_lock_fsm
    import spg_pkg::*;
#(
    parameter int MAX_DLY = 4,
    parameter int DLY_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ring_sel,
    input  logic             strobe,
    input  logic [DLY_W-1:0] dly_code,
    input  logic             phase_evt,
    output logic             fire,
    output spg_state_e       state
);
    localparam logic [DLY_W-1:0] DMAX = DLY_W'(MAX_DLY);

    spg_state_e       nxt;
    logic [DLY_W-1:0] dcnt, dcnt_nxt;
    logic [DLY_W-1:0] d_eff;

    assign d_eff = (dly_code > DMAX) ? DMAX : dly_code;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RING;
            dcnt  <= '0;
        end else begin
            state <= nxt;
            dcnt  <= dcnt_nxt;
        end
    end

    always_comb begin
        nxt      = state;
        dcnt_nxt = dcnt;
        fire     = 1'b0;
        unique case (state)
            ST_RING: begin
                fire = phase_evt;
                if (!ring_sel) nxt = ST_LOCK_WAIT;
            end
            ST_LOCK_WAIT: begin
                if (ring_sel) begin
                    nxt = ST_RING;
                end else if (strobe) begin
                    if (d_eff == '0) begin
                        fire = 1'b1;
                    end else begin
                        nxt      = ST_LOCK_DELAY;
                        dcnt_nxt = d_eff - 1'b1;
                    end
                end
            end
            ST_LOCK_DELAY: begin
                if (ring_sel) begin
                    nxt = ST_RING;
                end else if (dcnt == '0) begin
                    fire = 1'b1;
                    nxt  = ST_LOCK_WAIT;
                end else begin
                    dcnt_nxt = dcnt - 1'b1;
                end
            end
            default: nxt = ST_RING;
        endcase
    end
endmodule

// File: rtl/spg_samp_gen.sv
module spg_samp_gen
    import spg_pkg::*;
#(
    parameter int SAMP_MOD  = 40,
    parameter int LONG_20HZ = 4480,
    parameter int LONG_25HZ = 3560,
    parameter int LONG_50HZ = 1800,
    parameter int MAX_DLY   = 4,
    parameter int DLY_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ring_en,
    input  logic             off_hook,
    input  logic [1:0]       fsel,
    input  logic [DLY_W-1:0] dly_code,
    input  logic             drv_en,
    input  logic             oc_trip,
    input  logic             ph2_rise,
    output logic             samp_pulse
);
    logic       ring_sel;
    logic       long_wrap;
    logic       slip;
    logic       phase_evt;
    logic       fire;
    logic       gate_ok;
    spg_state_e state_w;

    assign ring_sel = ring_en && !off_hook && (fsel != 2'b11);
    assign slip     = long_wrap && (state_w == ST_RING);
    assign gate_ok  = drv_en && !oc_trip;

    spg_long_div #(
        .LONG_20HZ(LONG_20HZ),
        .LONG_25HZ(LONG_25HZ),
        .LONG_50HZ(LONG_50HZ)
    ) u_long (
        .clk  (clk),
        .rst_n(rst_n),
        .fsel (fsel),
        .wrap (long_wrap)
    );

    spg_phase_ctr #(
        .SAMP_MOD(SAMP_MOD)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (slip),
        .wrap_evt(phase_evt)
    );

    spg_lock_fsm #(
        .MAX_DLY(MAX_DLY),
        .DLY_W  (DLY_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ring_sel (ring_sel),
        .strobe   (ph2_rise),
        .dly_code (dly_code),
        .phase_evt(phase_evt),
        .fire     (fire),
        .state    (state_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) samp_pulse <= 1'b0;
        else        samp_pulse <= fire && gate_ok;
    end
endmodule

// File: rtl/spg_samp_gen_chk.sv
module spg_samp_gen_chk
    import spg_pkg::*;
#(
    parameter int MAX_DLY = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ring_en,
    input logic       off_hook,
    input logic [1:0] fsel,
    input logic       drv_en,
    input logic       oc_trip,
    input logic       ph2_rise,
    input logic       samp_pulse,
    input spg_state_e st
);
    logic [7:0] since_strobe;

    always_ff @(posedge clk) begin
        if (!rst_n)                    since_strobe <= 8'hFF;
        else if (ph2_rise)             since_strobe <= 8'h00;
        else if (since_strobe != 8'hFF) since_strobe <= since_strobe + 8'd1;
    end

    p_one_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
        samp_pulse |=> !samp_pulse);

    p_ring_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_en && !off_hook && fsel != 2'b11) |=> (st == ST_RING));

    p_lock_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_en || off_hook) |=> (st != ST_RING));

    p_fs3_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel == 2'b11) |=> (st != ST_RING));

    p_strobe_near_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_pulse && st != ST_RING && $past(st) != ST_RING)
            |-> (since_strobe <= 8'(MAX_DLY)));

    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_en || oc_trip) |=> !samp_pulse);
endmodule

bind spg_samp_gen spg_samp_gen_chk #(.MAX_DLY(MAX_DLY)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_en   (ring_en),
    .off_hook  (off_hook),
    .fsel      (fsel),
    .drv_en    (drv_en),
    .oc_trip   (oc_trip),
    .ph2_rise  (ph2_rise),
    .samp_pulse(samp_pulse),
    .st        (state_w)
);

// File: tb/test_spg_samp_gen.sv
module test_spg_samp_gen;
    localparam int M   = 8;
    localparam int L20 = 40;
    localparam int L25 = 30;
    localparam int L50 = 20;
    localparam int MD  = 4;
    localparam int DW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ring_en = 1'b0;
    logic          off_hook = 1'b0;
    logic [1:0]    fsel = 2'b00;
    logic [DW-1:0] dly_code = '0;
    logic          drv_en = 1'b1;
    logic          oc_trip = 1'b0;
    logic          ph2_rise = 1'b0;
    logic          samp_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int last_p, first_p, n_p, n_long, n_bad;

    spg_samp_gen #(
        .SAMP_MOD(M), .LONG_20HZ(L20), .LONG_25HZ(L25), .LONG_50HZ(L50),
        .MAX_DLY(MD), .DLY_W(DW)
    ) i_spg_samp_gen (
        .clk(clk), .rst_n(rst_n), .ring_en(ring_en), .off_hook(off_hook),
        .fsel(fsel), .dly_code(dly_code), .drv_en(drv_en), .oc_trip(oc_trip),
        .ph2_rise(ph2_rise), .samp_pulse(samp_pulse)
    );

    always #5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Steps n clocks, tracking pulse intervals.
    task automatic watch(input int n);
        last_p = -1; first_p = -1; n_p = 0; n_long = 0; n_bad = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (samp_pulse) begin
                if (last_p >= 0) begin
                    if (cyc - last_p == M + 1) n_long++;
                    else if (cyc - last_p != M) n_bad++;
                end else first_p = cyc;
                last_p = cyc;
                n_p++;
            end
        end
    endtask

    // Sends a strobe and checks the pulse lands exactly d_exp clocks after it.
    task automatic strobe_check(input string req, input int d_exp, input bit expect_pulse);
        int seen;
        int hits;
        seen = -1; hits = 0;
        ph2_rise = 1'b1;
        step();
        ph2_rise = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (samp_pulse) begin seen = k; hits++; end
            step();
        end
        if (expect_pulse) begin
            check(req, seen, d_exp);
            check(req, hits, 1);
        end else begin
            check(req, hits, 0);
        end
        repeat (20) step();
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int span, exp_l, delta, t0;
        repeat (3) step();
        // R1: reset state
        check("R1 pulse low in reset", int'(samp_pulse), 0);
        rst_n = 1'b1;
        ring_en = 1'b1;
        step();
        check("R1 no pulse right after reset", int'(samp_pulse), 0);

        // R2/R3: ring mode for each selectable long modulus
        for (int f = 0; f < 3; f++) begin
            fsel = 2'(f);
            repeat (60) step();
            watch(420);
            span  = last_p - first_p;
            exp_l = span / ((f == 0) ? L20 : (f == 1) ? L25 : L50);
            check("R2 intervals only M or M+1", n_bad, 0);
            check("R2 pulses present", int'(n_p > 40), 1);
            check("R3 long-interval count", int'(n_long >= exp_l - 1 && n_long <= exp_l + 1), 1);
            check("R3 span consistency", span, (n_p - 1) * M + n_long);
        end

        // R9: fsel 11 with ringing gives lock mode, no free-running pulses
        fsel = 2'b11;
        repeat (5) step();
        watch(100);
        check("R9 fsel=11 silent without strobe", n_p, 0);
        dly_code = 3'd2;
        strobe_check("R9 fsel=11 lock pulse", 2, 1'b1);
        fsel = 2'b00;

        // R5/R7: off-hook lock mode, every delay code
        off_hook = 1'b1;
        repeat (5) step();
        for (int c = 0; c < 8; c++) begin
            dly_code = 3'(c);
            strobe_check((c > MD) ? "R7 delay clamp" : "R5 delay code", (c > MD) ? MD : c, 1'b1);
        end
        // R6: no pulse without strobe
        watch(100);
        check("R6 lock silent without strobe", n_p, 0);

        // R4: ringing off, on hook -> lock mode
        off_hook = 1'b0;
        ring_en  = 1'b0;
        repeat (5) step();
        watch(60);
        check("R4 ring_en low gives no ring pulses", n_p, 0);
        dly_code = 3'd1;
        strobe_check("R4 ring_en low lock pulse", 1, 1'b1);

        // R8: gating in lock mode
        drv_en = 1'b0;
        strobe_check("R8 drv_en low suppresses lock", 0, 1'b0);
        drv_en = 1'b1;
        oc_trip = 1'b1;
        strobe_check("R8 oc_trip suppresses lock", 0, 1'b0);
        oc_trip = 1'b0;

        // R8: gating in ring mode
        ring_en = 1'b1;
        repeat (5) step();
        drv_en = 1'b0;
        watch(100);
        check("R8 drv_en low suppresses ring", n_p, 0);
        drv_en = 1'b1;
        oc_trip = 1'b1;
        watch(100);
        check("R8 oc_trip suppresses ring", n_p, 0);
        oc_trip = 1'b0;
        watch(50);
        check("R8 ring pulses resume", int'(n_p > 3), 1);

        // R10: phase continuity through a short lock excursion
        fsel = 2'b00;
        repeat (30) step();
        t0 = -1;
        for (int i = 0; i < 20 && t0 < 0; i++) begin
            step();
            if (samp_pulse) t0 = cyc;
        end
        off_hook = 1'b1;
        repeat (20) step();
        off_hook = 1'b0;
        watch(12);
        delta = first_p - t0;
        check("R10 resume phase", int'(delta == 3 * M || delta == 3 * M + 1), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule